// File: doc/BRIEF.md
# Fault Monitor with Sticky Diagnostics

This block gathers the digital outputs of the analog fault comparators around a gate-driver bridge. It covers regulator over- and undervoltage, a junction temperature warning, main supply over- and undervoltage, one undervoltage flag per gate output, and overvoltage on a set of logic pins. Each comparator output is resynchronised to the core clock. A live fault then sets a sticky diagnostic bit that stays set until software clears it. The bits are grouped into three registers: status, supply diagnostics and gate diagnostics.

Some fault classes also force every gate output low through `drive_off`. Supply undervoltage and regulator undervoltage always do this, and the outputs recover on their own once the live fault is gone. A logic-pin overvoltage does this only when the affected pin is one of the inputs and `cfg_pin_kill` is set. Every source can be masked. A masked source leaves its bit alone and never contributes to `drive_off`. Hysteresis is applied by the comparators outside this block.

Top module: `fault_diag_monitor`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), status_reg, supply_reg and gate_reg read all zeros and drive_off is 0.
- R2: A comparator input that rises is not visible two rising edges later. It is visible in its sticky bit after the third rising edge (two synchroniser stages, then the latch).
- R3: Regulator overvoltage (supply_reg bit 0), supply overvoltage (supply_reg bit 2), the temperature warning (status_reg bit 0) and gate undervoltage (gate_reg) each set their own bit and never assert drive_off.
- R4: Regulator undervoltage (supply_reg bit 1) and supply undervoltage (supply_reg bit 3) each set their bit and hold drive_off at 1 while live. drive_off returns to 0 three rising edges after the comparator falls.
- R5: Gate undervoltage bit i is set only when cmp_gate_uv[i] is seen while gate_active[i] is 1.
- R6: Overvoltage on any logic pin sets the shared status_reg bit 1. It asserts drive_off only when that pin is marked as an input by PIN_IS_INPUT (default: pins 0 to 4 are inputs, pin 5 is not) and cfg_pin_kill is 1. drive_off releases once no input pin is in fault.
- R7: A source whose mask bit is 1 neither sets its sticky bit nor asserts drive_off. Each mask bit sits at the same position as the bit it masks in the matching register.
- R8: A sticky bit stays set after its live fault clears, until a one-cycle pulse on its clear bit (same position in clr_status, clr_supply or clr_gate).
- R9: A clear that arrives while the fault is still live leaves the bit set, so setting takes priority over clearing.
- R10: A clear pulse affects only the bit at its own position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_reg_ov | input | 1 | Regulator overvoltage comparator |
| cmp_reg_uv | input | 1 | Regulator undervoltage comparator |
| cmp_temp | input | 1 | Temperature warning comparator |
| cmp_sup_ov | input | 1 | Main supply overvoltage comparator |
| cmp_sup_uv | input | 1 | Main supply undervoltage comparator |
| cmp_gate_uv | input | NUM_GATES | Per-output gate undervoltage comparators |
| gate_active | input | NUM_GATES | Gate output i currently driven on (synchronous) |
| cmp_pin_ov | input | NUM_PINS | Per-pin logic overvoltage comparators |
| mask_status | input | 2 | Masks for status_reg bits |
| mask_supply | input | 4 | Masks for supply_reg bits |
| mask_gate | input | NUM_GATES | Masks for gate_reg bits |
| cfg_pin_kill | input | 1 | Let input-pin overvoltage disable the outputs |
| clr_status | input | 2 | Clear strobes for status_reg |
| clr_supply | input | 4 | Clear strobes for supply_reg |
| clr_gate | input | NUM_GATES | Clear strobes for gate_reg |
| status_reg | output | 2 | Bit 0 temperature warning, bit 1 pin overvoltage |
| supply_reg | output | 4 | Bit 0 reg OV, bit 1 reg UV, bit 2 supply OV, bit 3 supply UV |
| gate_reg | output | NUM_GATES | Gate undervoltage per output |
| drive_off | output | 1 | Force all gate outputs low |

## Verification
The assertions check several properties on every cycle. A sticky bit never drops without its clear strobe. A clear never wins over a live set. A bit never rises without a qualified set. Masked supply bits and gate bits whose output was idle never rise. A disable request always shows on drive_off one edge later. The bench scenarios cover what needs a sequence of stimuli: the exact three-edge latency, recovery once an undervoltage is gone, the input-pin and config condition for a pin overvoltage, and clear strobes that touch only their own bit.

// File: rtl/fdm_pkg.sv
// Package: shared register bit positions and the width of the comparator bundle.
// Assumes every module using it imports it before declaring ports.
package fdm_pkg;
    // positions in the synchronised comparator vector
    localparam int CMP_REG_OV = 0;
    localparam int CMP_REG_UV = 1;
    localparam int CMP_TEMP   = 2;
    localparam int CMP_SUP_OV = 3;
    localparam int CMP_SUP_UV = 4;
    localparam int CMP_FIXED  = 5;

    // supply register bit positions
    localparam int SB_REG_OV = 0;
    localparam int SB_REG_UV = 1;
    localparam int SB_SUP_OV = 2;
    localparam int SB_SUP_UV = 3;
    localparam int SUPPLY_W  = 4;

    // status register bit positions
    localparam int TB_TEMP  = 0;
    localparam int TB_PIN   = 1;
    localparam int STATUS_W = 2;

    // reasons the outputs are being forced low
    typedef struct packed {
        logic reg_uv;
        logic sup_uv;
        logic pin_in;
    } kill_src_t;
endpackage

// File: rtl/fdm_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous comparator outputs.
// Assumes each bit is independent; no multi-bit coherence is implied.
module fdm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // two-stage capture of the raw comparator levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/fdm_sticky.sv
// Module: bank of sticky diagnostic bits; set has priority over clear.
// Assumes set is already masked and qualified, and clr is a per-bit strobe.
module fdm_sticky #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            // latch one diagnostic bit: set wins, clear only when idle
            always_ff @(posedge clk) begin
                if (!rst_n)       q[i] <= 1'b0;
                else if (set[i])  q[i] <= 1'b1;
                else if (clr[i])  q[i] <= 1'b0;
            end
        end
    endgenerate

    // R8: a set bit without a clear stays set
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((q & ~clr) != '0) |=> (($past(q & ~clr) & ~q) == '0));

    // R9: a live set is never lost to a simultaneous clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> (($past(set) & ~q) == '0));

    // R8: no bit rises without a set
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q != '1) |=> ((q & ~$past(q) & ~$past(set)) == '0));
endmodule

// File: rtl/fdm_action.sv
// Module: registered gate-drive disable built from the live disabling faults.
// Assumes its inputs are already masked; recovery is automatic when all are low.
module fdm_action
    import fdm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  kill_src_t kill,
    output logic      drive_off
);
    logic any_kill;

    // merge every reason that forces outputs low
    always_comb any_kill = kill.reg_uv | kill.sup_uv | kill.pin_in;

    // register the disable so the gate path sees a clean level
    always_ff @(posedge clk) begin
        if (!rst_n) drive_off <= 1'b0;
        else        drive_off <= any_kill;
    end

    // R4: an undervoltage request reaches drive_off on the next edge
    p_uv_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kill.sup_uv || kill.reg_uv) |=> drive_off);

    // R6: once all requests are gone the outputs recover
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_off && !kill.sup_uv && !kill.reg_uv && !kill.pin_in) |=> !drive_off);
endmodule

// File: rtl/fault_diag_monitor.sv
// Module: top of the fault monitor. Synchronises comparator flags, qualifies
// and masks them, latches sticky diagnostics and drives the output disable.
// Assumes gate_active, masks, config and clear strobes are synchronous to clk.
module fault_diag_monitor
    import fdm_pkg::*;
#(
    parameter int                NUM_GATES    = 4,
    parameter int                NUM_PINS     = 6,
    parameter logic [NUM_PINS-1:0] PIN_IS_INPUT = 6'b011111
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmp_reg_ov,
    input  logic                 cmp_reg_uv,
    input  logic                 cmp_temp,
    input  logic                 cmp_sup_ov,
    input  logic                 cmp_sup_uv,
    input  logic [NUM_GATES-1:0] cmp_gate_uv,
    input  logic [NUM_GATES-1:0] gate_active,
    input  logic [NUM_PINS-1:0]  cmp_pin_ov,
    input  logic [1:0]           mask_status,
    input  logic [3:0]           mask_supply,
    input  logic [NUM_GATES-1:0] mask_gate,
    input  logic                 cfg_pin_kill,
    input  logic [1:0]           clr_status,
    input  logic [3:0]           clr_supply,
    input  logic [NUM_GATES-1:0] clr_gate,
    output logic [1:0]           status_reg,
    output logic [3:0]           supply_reg,
    output logic [NUM_GATES-1:0] gate_reg,
    output logic                 drive_off
);
    localparam int SYNC_W   = CMP_FIXED + NUM_GATES + NUM_PINS;
    localparam int GATE_LSB = CMP_FIXED;
    localparam int PIN_LSB  = CMP_FIXED + NUM_GATES;

    logic [SYNC_W-1:0]    cmp_raw, cmp_s;
    logic [SUPPLY_W-1:0]  supply_set;
    logic [STATUS_W-1:0]  status_set;
    logic [NUM_GATES-1:0] gate_set;
    logic [NUM_PINS-1:0]  pin_live;
    kill_src_t            kill;

    // bundle the raw comparator outputs for the synchroniser
    always_comb cmp_raw = {cmp_pin_ov, cmp_gate_uv, cmp_sup_uv, cmp_sup_ov,
                           cmp_temp, cmp_reg_uv, cmp_reg_ov};

    fdm_sync #(.W(SYNC_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(cmp_raw), .q(cmp_s)
    );

    // mask and qualify the synchronised flags into per-register set vectors
    always_comb begin
        supply_set[SB_REG_OV] = cmp_s[CMP_REG_OV] & ~mask_supply[SB_REG_OV];
        supply_set[SB_REG_UV] = cmp_s[CMP_REG_UV] & ~mask_supply[SB_REG_UV];
        supply_set[SB_SUP_OV] = cmp_s[CMP_SUP_OV] & ~mask_supply[SB_SUP_OV];
        supply_set[SB_SUP_UV] = cmp_s[CMP_SUP_UV] & ~mask_supply[SB_SUP_UV];
        gate_set   = cmp_s[GATE_LSB +: NUM_GATES] & gate_active & ~mask_gate;
        pin_live   = cmp_s[PIN_LSB +: NUM_PINS];
        status_set[TB_TEMP] = cmp_s[CMP_TEMP] & ~mask_status[TB_TEMP];
        status_set[TB_PIN]  = (|pin_live) & ~mask_status[TB_PIN];
    end

    // collect the live faults that must force the outputs low
    always_comb begin
        kill.reg_uv = supply_set[SB_REG_UV];
        kill.sup_uv = supply_set[SB_SUP_UV];
        kill.pin_in = cfg_pin_kill & ~mask_status[TB_PIN] & (|(pin_live & PIN_IS_INPUT));
    end

    fdm_sticky #(.W(STATUS_W)) u_status (
        .clk(clk), .rst_n(rst_n), .set(status_set), .clr(clr_status), .q(status_reg)
    );
    fdm_sticky #(.W(SUPPLY_W)) u_supply (
        .clk(clk), .rst_n(rst_n), .set(supply_set), .clr(clr_supply), .q(supply_reg)
    );
    fdm_sticky #(.W(NUM_GATES)) u_gate (
        .clk(clk), .rst_n(rst_n), .set(gate_set), .clr(clr_gate), .q(gate_reg)
    );

    fdm_action u_action (
        .clk(clk), .rst_n(rst_n), .kill(kill), .drive_off(drive_off)
    );

    // R5: a gate bit only rises for an output that was active
    p_gate_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_reg != '1) |=> ((gate_reg & ~$past(gate_reg) & ~$past(gate_active)) == '0));

    // R7: a masked supply source never raises its bit
    p_mask_supply_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_reg != '1) |=> ((supply_reg & ~$past(supply_reg) & $past(mask_supply)) == '0));
endmodule

// File: tb/fault_diag_monitor_test.sv
`timescale 1ns/1ps
module fault_diag_monitor_test;
    localparam int G = 4;
    localparam int P = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_reg_ov = 0, cmp_reg_uv = 0, cmp_temp = 0, cmp_sup_ov = 0, cmp_sup_uv = 0;
    logic [G-1:0] cmp_gate_uv = '0, gate_active = '0, mask_gate = '0, clr_gate = '0;
    logic [P-1:0] cmp_pin_ov = '0;
    logic [1:0]   mask_status = '0, clr_status = '0;
    logic [3:0]   mask_supply = '0, clr_supply = '0;
    logic         cfg_pin_kill = 1'b0;
    logic [1:0]   status_reg;
    logic [3:0]   supply_reg;
    logic [G-1:0] gate_reg;
    logic         drive_off;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    fault_diag_monitor uut (
        .clk(clk), .rst_n(rst_n),
        .cmp_reg_ov(cmp_reg_ov), .cmp_reg_uv(cmp_reg_uv), .cmp_temp(cmp_temp),
        .cmp_sup_ov(cmp_sup_ov), .cmp_sup_uv(cmp_sup_uv),
        .cmp_gate_uv(cmp_gate_uv), .gate_active(gate_active), .cmp_pin_ov(cmp_pin_ov),
        .mask_status(mask_status), .mask_supply(mask_supply), .mask_gate(mask_gate),
        .cfg_pin_kill(cfg_pin_kill),
        .clr_status(clr_status), .clr_supply(clr_supply), .clr_gate(clr_gate),
        .status_reg(status_reg), .supply_reg(supply_reg), .gate_reg(gate_reg),
        .drive_off(drive_off)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // advance n rising edges, then settle on the falling edge
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiesce();
        cmp_reg_ov = 0; cmp_reg_uv = 0; cmp_temp = 0; cmp_sup_ov = 0; cmp_sup_uv = 0;
        cmp_gate_uv = '0; cmp_pin_ov = '0; gate_active = '0;
        mask_status = '0; mask_supply = '0; mask_gate = '0; cfg_pin_kill = 0;
        edges(3);
        clr_status = '1; clr_supply = '1; clr_gate = '1;
        edges(1);
        clr_status = '0; clr_supply = '0; clr_gate = '0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        edges(2);
        check("R1", "status", {14'b0, status_reg}, 16'h0);
        check("R1", "supply", {12'b0, supply_reg}, 16'h0);
        check("R1", "gate", {12'b0, gate_reg}, 16'h0);
        check("R1", "drive_off", {15'b0, drive_off}, 16'h0);
        rst_n = 1;
        edges(1);
    endtask

    task automatic t_latency();
        cmp_temp = 1;
        edges(2);
        check("R2", "temp after 2 edges", {14'b0, status_reg}, 16'h0);
        edges(1);
        check("R2", "temp after 3 edges", {14'b0, status_reg}, 16'h1);
        quiesce();
    endtask

    task automatic t_no_action();
        cmp_reg_ov = 1; cmp_sup_ov = 1; cmp_temp = 1;
        gate_active = 4'b1111; cmp_gate_uv = 4'b1010;
        edges(4);
        check("R3", "supply ov bits", {12'b0, supply_reg}, 16'h5);
        check("R3", "temp bit", {14'b0, status_reg}, 16'h1);
        check("R3", "gate bits", {12'b0, gate_reg}, 16'ha);
        check("R3", "no disable", {15'b0, drive_off}, 16'h0);
        quiesce();
    endtask

    task automatic t_uv();
        cmp_sup_uv = 1;
        edges(3);
        check("R4", "sup uv bit", {12'b0, supply_reg}, 16'h8);
        check("R4", "sup uv off", {15'b0, drive_off}, 16'h1);
        cmp_sup_uv = 0;
        edges(2);
        check("R4", "still off 2 edges after", {15'b0, drive_off}, 16'h1);
        edges(1);
        check("R4", "recovered", {15'b0, drive_off}, 16'h0);
        check("R8", "sup uv sticky", {12'b0, supply_reg}, 16'h8);
        cmp_reg_uv = 1;
        edges(3);
        check("R4", "reg uv off", {15'b0, drive_off}, 16'h1);
        check("R4", "reg uv bit", {12'b0, supply_reg}, 16'ha);
        quiesce();
        check("R4", "off cleared", {15'b0, drive_off}, 16'h0);
    endtask

    task automatic t_gate_qual();
        gate_active = 4'b0101; cmp_gate_uv = 4'b1111;
        edges(4);
        check("R5", "only active gates", {12'b0, gate_reg}, 16'h5);
        quiesce();
    endtask

    task automatic t_pin();
        cfg_pin_kill = 1; cmp_pin_ov = 6'b100000;
        edges(3);
        check("R6", "non-input pin bit", {14'b0, status_reg}, 16'h2);
        check("R6", "non-input pin no off", {15'b0, drive_off}, 16'h0);
        cmp_pin_ov = 6'b100100;
        edges(3);
        check("R6", "input pin off", {15'b0, drive_off}, 16'h1);
        cmp_pin_ov = 6'b100000;
        edges(3);
        check("R6", "released with no input pin", {15'b0, drive_off}, 16'h0);
        cfg_pin_kill = 0; cmp_pin_ov = 6'b000100;
        edges(3);
        check("R6", "config off no disable", {15'b0, drive_off}, 16'h0);
        quiesce();
    endtask

    task automatic t_mask();
        mask_supply = 4'b1000; mask_status = 2'b11; mask_gate = 4'b0001;
        cfg_pin_kill = 1; gate_active = 4'b1111;
        cmp_sup_uv = 1; cmp_temp = 1; cmp_pin_ov = 6'b000001; cmp_gate_uv = 4'b0001;
        edges(4);
        check("R7", "masked supply", {12'b0, supply_reg}, 16'h0);
        check("R7", "masked status", {14'b0, status_reg}, 16'h0);
        check("R7", "masked gate", {12'b0, gate_reg}, 16'h0);
        check("R7", "masked no off", {15'b0, drive_off}, 16'h0);
        quiesce();
    endtask

    task automatic t_clear();
        cmp_temp = 1; cmp_reg_ov = 1;
        edges(3);
        clr_status = 2'b01;
        edges(1);
        clr_status = '0;
        check("R9", "clear while live", {14'b0, status_reg}, 16'h1);
        cmp_temp = 0; cmp_reg_ov = 0;
        edges(4);
        check("R8", "sticky after fault", {14'b0, status_reg}, 16'h1);
        clr_supply = 4'b0001;
        edges(1);
        clr_supply = '0;
        check("R10", "supply bit cleared", {12'b0, supply_reg}, 16'h0);
        check("R10", "status untouched", {14'b0, status_reg}, 16'h1);
        clr_status = 2'b01;
        edges(1);
        clr_status = '0;
        check("R8", "status cleared", {14'b0, status_reg}, 16'h0);
        quiesce();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_latency();
        t_no_action();
        t_uv();
        t_gate_qual();
        t_pin();
        t_mask();
        t_clear();
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule